// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between a 12-bit narrow port (A) and a 24-bit wide port (B), with every path clocked. The wide port is handled as two 12-bit halves: the low half (1B, bits 11:0) and the high half (2B, bits 23:12). In the narrow-to-wide direction, the low-half path has two register stages and the high-half path has one. This difference in depth is what lets two narrow words, presented on consecutive cycles, leave together as a single wide word. Each path has its own active-low capture enable, and these steer which word ends up in which half.

In the wide-to-narrow direction, each half of B is captured in its own enabled register. A registered active-low select chooses which captured half drives A. The select and the two active-low output enables are sampled on the clock, so a change of direction or selection takes effect only at a clock edge. The bidirectional pins are modelled as separate data-in, data-out and output-enable signals; an output enable of 1 means the port drives. An optional synchronous reset puts both output enables into the non-driving state, so they are defined before normal operation starts.

Top module: `nw_bus_exchanger`

## Requirements
- R1: While `cap_a_lo_n` is 0 on consecutive rising edges, both stages of the low-half path advance together, and `b_out[11:0]` shows the `a_in` value that was sampled two enabled edges earlier.
- R2: A rising edge with `cap_a_hi_n` 0 loads `a_in` into the high-half register, and `b_out[23:12]` shows that value after the edge.
- R3: Word W0 is applied with `cap_a_lo_n`=0 and `cap_a_hi_n`=1, and word W1 is applied on the next edge with both enables at 0. After that second edge, `b_out` equals {W1, W0}.
- R4: A register whose capture enable is 1 at an edge keeps its value. `b_out` does not change when both A-side enables are 1, and `a_out` does not change when both B-side enables are 1 and `sel_n` is unchanged.
- R5: A rising edge with `cap_b_lo_n`=0 captures `b_in[11:0]`, and one with `cap_b_hi_n`=0 captures `b_in[23:12]`. When the registered `sel_n` is 0, `a_out` shows the captured low half; when it is 1, `a_out` shows the captured high half.
- R6: After each rising edge outside reset, `a_oe` equals the inverse of `oe_a_n` sampled at that edge, and `b_oe` equals the inverse of `oe_b_n`. An enable input at 1 therefore means the port is not driving.
- R7: With `HAS_SRST`=1, a rising edge with `srst`=1 sets `a_oe` and `b_oe` to 0, whatever `oe_a_n` and `oe_b_n` are.
- R8: A change of `sel_n`, `oe_a_n` or `oe_b_n` between edges does not alter `a_out`, `a_oe` or `b_oe` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register samples on its rising edge |
| srst | input | 1 | Synchronous reset of the output enables, active high |
| a_in | input | 12 | Data arriving on the narrow port |
| a_out | output | 12 | Data driven toward the narrow port |
| a_oe | output | 1 | Narrow-port drive enable, 1 = driving |
| b_in | input | 24 | Data arriving on the wide port |
| b_out | output | 24 | Data driven toward the wide port, {high half, low half} |
| b_oe | output | 1 | Wide-port drive enable, 1 = driving |
| cap_a_lo_n | input | 1 | Active-low advance of the two-stage low-half path |
| cap_a_hi_n | input | 1 | Active-low capture of the high-half register |
| cap_b_lo_n | input | 1 | Active-low capture of `b_in[11:0]` |
| cap_b_hi_n | input | 1 | Active-low capture of `b_in[23:12]` |
| oe_a_n | input | 1 | Active-low narrow-port output enable, registered |
| oe_b_n | input | 1 | Active-low wide-port output enable, registered |
| sel_n | input | 1 | Registered half select for A: 0 = low half, 1 = high half |

## Verification
The hardest case to reach from the ports is the gathering of two words. The wide word is only correct when the low-half enable is held over two edges while the high-half enable opens on the second edge only. Any slip in that sequence still yields a plausible-looking value, but with the wrong pairing. The bench therefore drives that exact enable sequence for a sweep of arithmetically generated word pairs and compares the result with {W1, W0}. It also runs a separate three-word run to show the depth of the low path on its own. Mid-cycle changes of select and enables are checked shortly before the next edge, to show that nothing moves until that edge.

// File: rtl/nwx_pkg.sv
package nwx_pkg;

   // registered control bundle; reset value puts both ports in the non-driving state
   typedef struct packed {
      logic oe_a_n;
      logic oe_b_n;
      logic sel_n;
   } nwx_ctrl_t;

   localparam nwx_ctrl_t NWX_CTRL_IDLE = '{oe_a_n: 1'b1, oe_b_n: 1'b1, sel_n: 1'b0};

endpackage

// File: rtl/nwx_en_reg.sv
module nwx_en_reg #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         en_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("nwx_en_reg: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!en_n) q <= d;
   end
endmodule

// File: rtl/nwx_pipe.sv
module nwx_pipe #(
   parameter int W     = 12,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         en_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("nwx_pipe: DEPTH must be at least 1");
   end

   logic [W-1:0] stg [DEPTH+1];
   assign stg[0] = d;

   // every stage shares the enable, so the chain advances as one
   for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      nwx_en_reg #(.W(W)) u_reg (
         .clk  (clk),
         .en_n (en_n),
         .d    (stg[s]),
         .q    (stg[s+1])
      );
   end

   assign q = stg[DEPTH];
endmodule

// File: rtl/nwx_ctrl_reg.sv
module nwx_ctrl_reg
   import nwx_pkg::*;
#(
   parameter bit HAS_SRST = 1'b1
) (
   input  logic      clk,
   input  logic      srst,
   input  nwx_ctrl_t d,
   output nwx_ctrl_t q
);
   if (HAS_SRST) begin : g_srst
      always_ff @(posedge clk) begin
         if (srst) q <= NWX_CTRL_IDLE;
         else      q <= d;
      end
   end else begin : g_nosrst
      logic unused_srst;
      assign unused_srst = srst;
      always_ff @(posedge clk) q <= d;
   end
endmodule

// File: rtl/nw_bus_exchanger.sv
module nw_bus_exchanger
   import nwx_pkg::*;
#(
   parameter int NARROW_W = 12,
   parameter bit HAS_SRST = 1'b1
) (
   input  logic                  clk,
   input  logic                  srst,
   input  logic [NARROW_W-1:0]   a_in,
   output logic [NARROW_W-1:0]   a_out,
   output logic                  a_oe,
   input  logic [2*NARROW_W-1:0] b_in,
   output logic [2*NARROW_W-1:0] b_out,
   output logic                  b_oe,
   input  logic                  cap_a_lo_n,
   input  logic                  cap_a_hi_n,
   input  logic                  cap_b_lo_n,
   input  logic                  cap_b_hi_n,
   input  logic                  oe_a_n,
   input  logic                  oe_b_n,
   input  logic                  sel_n
);
   localparam int WIDE_W   = 2 * NARROW_W;
   localparam int HI_DEPTH = 1;
   localparam int LO_DEPTH = HI_DEPTH + 1;   // one extra stage lines up consecutive words

   if (NARROW_W < 1) begin : g_bad_width
      $error("nw_bus_exchanger: NARROW_W must be at least 1");
   end

   // ---------------- narrow to wide ----------------
   logic [NARROW_W-1:0] lo_q, hi_q;

   nwx_pipe #(.W(NARROW_W), .DEPTH(LO_DEPTH)) u_lo_path (
      .clk (clk), .en_n (cap_a_lo_n), .d (a_in), .q (lo_q)
   );

   nwx_pipe #(.W(NARROW_W), .DEPTH(HI_DEPTH)) u_hi_path (
      .clk (clk), .en_n (cap_a_hi_n), .d (a_in), .q (hi_q)
   );

   assign b_out = {hi_q, lo_q};

   // ---------------- wide to narrow ----------------
   logic [1:0]          b_cap_n;
   logic [NARROW_W-1:0] b_half_q [2];

   assign b_cap_n = {cap_b_hi_n, cap_b_lo_n};

   for (genvar h = 0; h < 2; h++) begin : g_b_half
      nwx_en_reg #(.W(NARROW_W)) u_cap (
         .clk  (clk),
         .en_n (b_cap_n[h]),
         .d    (b_in[h*NARROW_W +: NARROW_W]),
         .q    (b_half_q[h])
      );
   end

   // ---------------- registered controls ----------------
   nwx_ctrl_t ctrl_d, ctrl_q;

   assign ctrl_d = '{oe_a_n: oe_a_n, oe_b_n: oe_b_n, sel_n: sel_n};

   nwx_ctrl_reg #(.HAS_SRST(HAS_SRST)) u_ctrl (
      .clk (clk), .srst (srst), .d (ctrl_d), .q (ctrl_q)
   );

   assign a_out = ctrl_q.sel_n ? b_half_q[1] : b_half_q[0];
   assign a_oe  = ~ctrl_q.oe_a_n;
   assign b_oe  = ~ctrl_q.oe_b_n;

   // ---------------- assertions ----------------
   assert_lo_two_stage_R1: assert property (@(posedge clk) disable iff (srst)
      (!cap_a_lo_n ##1 !cap_a_lo_n) |=> b_out[NARROW_W-1:0] == $past(a_in, 2));

   assert_hi_one_stage_R2: assert property (@(posedge clk) disable iff (srst)
      !cap_a_hi_n |=> b_out[WIDE_W-1:NARROW_W] == $past(a_in));

   assert_gather_pair_R3: assert property (@(posedge clk) disable iff (srst)
      (!cap_a_lo_n ##1 (!cap_a_lo_n && !cap_a_hi_n)) |=> b_out == {$past(a_in), $past(a_in, 2)});

   assert_hold_hi_R4: assert property (@(posedge clk) disable iff (srst)
      cap_a_hi_n |=> $stable(b_out[WIDE_W-1:NARROW_W]));

   assert_hold_lo_R4: assert property (@(posedge clk) disable iff (srst)
      cap_a_lo_n |=> $stable(b_out[NARROW_W-1:0]));

   assert_sel_low_R5: assert property (@(posedge clk) disable iff (srst)
      (!cap_b_lo_n && !sel_n) |=> a_out == $past(b_in[NARROW_W-1:0]));

   assert_sel_high_R5: assert property (@(posedge clk) disable iff (srst)
      (!cap_b_hi_n && sel_n) |=> a_out == $past(b_in[WIDE_W-1:NARROW_W]));

   assert_oe_follow_R6: assert property (@(posedge clk) disable iff (srst)
      1'b1 |=> (a_oe == !$past(oe_a_n)) && (b_oe == !$past(oe_b_n)));
endmodule

// File: tb/tb_nw_bus_exchanger.sv
module tb_nw_bus_exchanger;
   localparam int NW = 12;
   localparam int WW = 2 * NW;

   logic          clk = 1'b0;
   logic          srst = 1'b1;
   logic [NW-1:0] a_in = '0;
   logic [NW-1:0] a_out;
   logic          a_oe;
   logic [WW-1:0] b_in = '0;
   logic [WW-1:0] b_out;
   logic          b_oe;
   logic          cap_a_lo_n = 1'b1, cap_a_hi_n = 1'b1;
   logic          cap_b_lo_n = 1'b1, cap_b_hi_n = 1'b1;
   logic          oe_a_n = 1'b0, oe_b_n = 1'b0, sel_n = 1'b0;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   nw_bus_exchanger #(.NARROW_W(NW), .HAS_SRST(1'b1)) dut (
      .clk (clk), .srst (srst),
      .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
      .b_in (b_in), .b_out (b_out), .b_oe (b_oe),
      .cap_a_lo_n (cap_a_lo_n), .cap_a_hi_n (cap_a_hi_n),
      .cap_b_lo_n (cap_b_lo_n), .cap_b_hi_n (cap_b_hi_n),
      .oe_a_n (oe_a_n), .oe_b_n (oe_b_n), .sel_n (sel_n)
   );

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   initial begin
      logic [NW-1:0] w0, w1, u0, u1, u2, p, q;
      logic [WW-1:0] b_keep;
      logic [NW-1:0] a_keep;

      // R7: reset forces both drive enables off even with enables requested
      tick(); tick();
      chk("R7 a_oe in reset", {23'd0, a_oe}, 24'd0);
      chk("R7 b_oe in reset", {23'd0, b_oe}, 24'd0);
      srst = 1'b0;
      tick();
      chk("R6 a_oe after reset", {23'd0, a_oe}, 24'd1);
      chk("R6 b_oe after reset", {23'd0, b_oe}, 24'd1);

      // R6 / R8: sweep of enable combinations, mid-cycle change held off until the edge
      for (int k = 0; k < 4; k++) begin
         logic old_a, old_b;
         old_a  = a_oe;
         old_b  = b_oe;
         oe_a_n = k[0];
         oe_b_n = k[1];
         #8;
         chk("R8 a_oe before edge", {23'd0, a_oe}, {23'd0, old_a});
         chk("R8 b_oe before edge", {23'd0, b_oe}, {23'd0, old_b});
         tick();
         chk("R6 a_oe", {23'd0, a_oe}, {23'd0, ~k[0]});
         chk("R6 b_oe", {23'd0, b_oe}, {23'd0, ~k[1]});
      end

      // R3 sweep of word pairs with R4 hold after each
      for (int i = 0; i < 16; i++) begin
         w0 = NW'((i * 12'h35B + 7));
         w1 = NW'(~w0 ^ NW'(i << 4));
         a_in = w0; cap_a_lo_n = 1'b0; cap_a_hi_n = 1'b1;
         tick();
         a_in = w1; cap_a_lo_n = 1'b0; cap_a_hi_n = 1'b0;
         tick();
         chk("R3 gathered wide word", b_out, {w1, w0});
         a_in = NW'(i * 12'h9D1); cap_a_lo_n = 1'b1; cap_a_hi_n = 1'b1;
         tick(); tick();
         chk("R4 b_out held", b_out, {w1, w0});
      end

      // R1: three-word run through the low path
      u0 = 12'h1A5; u1 = 12'hC3E; u2 = 12'h07F;
      cap_a_lo_n = 1'b0; cap_a_hi_n = 1'b1;
      a_in = u0; tick();
      a_in = u1; tick();
      a_in = u2; tick();
      chk("R1 low half two stages", {12'd0, b_out[NW-1:0]}, {12'd0, u1});
      cap_a_lo_n = 1'b1;

      // R2: single-stage high path
      a_in = 12'hBEE; cap_a_hi_n = 1'b0;
      tick();
      chk("R2 high half one stage", {12'd0, b_out[WW-1:NW]}, {12'd0, 12'hBEE});
      cap_a_hi_n = 1'b1;

      // R5 sweep: capture both halves, pick each through registered select
      for (int j = 0; j < 8; j++) begin
         p = NW'(j * 12'h2C9 + 12'h101);
         q = NW'(~(j * 12'h14F));
         b_in = {p, q}; cap_b_lo_n = 1'b0; cap_b_hi_n = 1'b0; sel_n = 1'b0;
         tick();
         chk("R5 select low half", {12'd0, a_out}, {12'd0, q});
         cap_b_lo_n = 1'b1; cap_b_hi_n = 1'b1;
         sel_n = 1'b1;
         #8;
         chk("R8 a_out before edge", {12'd0, a_out}, {12'd0, q});
         tick();
         chk("R5 select high half", {12'd0, a_out}, {12'd0, p});
         b_in = ~{p, q};
         tick();
         chk("R4 a_out held", {12'd0, a_out}, {12'd0, p});
         sel_n = 1'b0;
         tick();
         chk("R4 low capture held", {12'd0, a_out}, {12'd0, q});
      end

      // R4: B side captures do not disturb the wide output
      b_keep = b_out;
      a_keep = a_out;
      b_in = 24'h5A5A5A;
      tick();
      chk("R4 b_out unaffected by B side", b_out, b_keep);
      chk("R4 a_out stable", {12'd0, a_out}, {12'd0, a_keep});

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule